// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is a small register bank that sits beside a processor core. The core reaches it only through register-move transfers. A write transfer copies a core register into one of the bank's slots. A read transfer returns a slot's contents to the core. Any other kind of coprocessor request is answered with a refusal, which the core turns into an undefined-instruction trap.

The bank has eight 32-bit slots. Slot 0 holds a fixed identification word and stores nothing. Slot 1 holds four processor mode controls and drives them out as level signals: wide program space, wide data space, late abort timing and big-endian byte order. At reset these four controls are taken from external strap pins. Every write to slot 1 re-drives them at once and raises a one-cycle "mode changed" flag, so that the core samples them again. Slots 2 to 7 are plain storage.

Each request is answered one clock after it is presented. The answer is either a done flag, with read data when the request was a read, or the refusal flag.

Top module: `sysctl_cp_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done_o`, `cant_o` and `mode_chg_o` are low and `rdata_o` is zero.
- R2: A request is a register move when `instr_i[27:24]` is 4'b1110 and `instr_i[4]` is 1. `dir_rd_i`=1 selects a read and 0 selects a write. The slot index is `instr_i[18:16]`, and `instr_i[19]` is ignored, so indices 8 to 15 alias slots 0 to 7.
- R3: An accepted move raises `done_o` for exactly the one cycle after the request. A read puts the slot's contents on `rdata_o` in that same cycle. `rdata_o` holds its value until the next accepted read.
- R4: A read of slot 0 always returns 0x41440110. Writes to slot 0 have no effect.
- R5: In slot 1, bit 4 drives `prog_wide_o`, bit 5 drives `data_wide_o`, bit 6 drives `late_abort_o` and bit 7 drives `big_endian_o`. All other bits of slot 1 read as zero.
- R6: During reset the four control outputs follow `strap_mode_i[3:0]`, with strap bit k mapped to slot 1 bit 4+k. After reset, slot 1 holds those strap values until it is written.
- R7: A write to slot 1 updates the four control outputs in the cycle after the request, and `mode_chg_o` pulses high in that cycle together with `done_o`. Writes to other slots never pulse `mode_chg_o`. The control outputs never change on their own.
- R8: Slots 2 to 7 return the last value written to them, and zero if they have not been written since reset.
- R9: A request that is not a register move raises `cant_o` for the cycle after it, with `done_o` low. It changes no slot and leaves `rdata_o` unchanged.
- R10: `done_o` and `cant_o` are never high together, and neither rises in a cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Transfer strobe, one request per cycle |
| dir_rd_i | input | 1 | 1 = read a slot, 0 = write a slot |
| instr_i | input | 32 | Coprocessor instruction word |
| wdata_i | input | 32 | Write data from the core |
| strap_mode_i | input | 4 | Reset-time values for slot 1 bits 7:4 |
| rdata_o | output | 32 | Read data, valid with done after a read |
| done_o | output | 1 | Accepted transfer completed |
| cant_o | output | 1 | Request refused |
| mode_chg_o | output | 1 | One-cycle pulse after a write to slot 1 |
| prog_wide_o | output | 1 | Wide program space control |
| data_wide_o | output | 1 | Wide data space control |
| late_abort_o | output | 1 | Late abort timing control |
| big_endian_o | output | 1 | Big-endian byte order control |

## Verification
The assertions check on every cycle that each request gets exactly one kind of answer on the next cycle. They also check that responses never appear without a request, that a slot 0 read returns the identification word, and that the control outputs move only together with a mode-change pulse. Other behaviours can only be shown by the bench's scenarios, because they depend on history: stored values surviving later traffic, aliasing through the ignored index bit, the strap-derived reset contents of slot 1, the masking of its unused bits, and refused requests leaving storage and read data untouched. To cover these, the bench keeps an arithmetic model of all eight slots. It sweeps writes over every one of the sixteen encodable indices and reads back all slots after each write.

// File: rtl/sysctl_cp_pkg.sv
package sysctl_cp_pkg;

  localparam int unsigned CTL_BITS = 4;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_REFUSE = 2'd3
  } cp_op_e;

  typedef struct packed {
    logic done;
    logic cant;
    logic mode_chg;
  } cp_resp_t;

  // Register-move class: bits 27:24 equal 4'b1110 and bit 4 set.
  function automatic logic is_reg_move(input logic [31:0] word);
    return (word[27:24] == 4'b1110) && word[4];
  endfunction

endpackage

// File: rtl/sysctl_cp_decode.sv
module sysctl_cp_decode
  import sysctl_cp_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned CTRL_SLOT = 1,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             req_i,
  input  logic             dir_rd_i,
  input  logic [31:0]      instr_i,
  output cp_op_e           op_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ctl_wr_o
);

  logic move;
  logic unused_instr_bits;

  assign move  = is_reg_move(instr_i);
  assign idx_o = instr_i[16 +: IDX_W];
  assign unused_instr_bits = ^{instr_i[31:28], instr_i[23:19], instr_i[15:5], instr_i[3:0]};

  always_comb begin
    op_o = OP_NONE;
    if (req_i) begin
      if (!move)         op_o = OP_REFUSE;
      else if (dir_rd_i) op_o = OP_READ;
      else               op_o = OP_WRITE;
    end
  end

  assign ctl_wr_o = (op_o == OP_WRITE) && (idx_o == IDX_W'(CTRL_SLOT));

endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
  import sysctl_cp_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned CTRL_SLOT = 1,
  parameter int unsigned CTRL_LSB  = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h41440110,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [CTL_BITS-1:0] strap_i,
  output logic [DATA_W-1:0]   rd_word_o,
  output logic [CTL_BITS-1:0] ctl_o
);

  logic [DATA_W-1:0] slot_word [NUM_REGS];

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
    if (s == 0) begin : g_id
      assign slot_word[s] = ID_VALUE;
    end else if (s == CTRL_SLOT) begin : g_ctl
      logic                loaded_q, loaded_d;
      logic [CTL_BITS-1:0] ctl_q, ctl_d, ctl_eff;
      logic                wr_hit;

      assign wr_hit  = wr_en_i && (idx_i == IDX_W'(s));
      assign ctl_eff = loaded_q ? ctl_q : strap_i;

      always_comb begin
        loaded_d = 1'b1;
        ctl_d    = ctl_eff;
        if (wr_hit) ctl_d = wdata_i[CTRL_LSB +: CTL_BITS];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          loaded_q <= 1'b0;
          ctl_q    <= '0;
        end else begin
          loaded_q <= loaded_d;
          ctl_q    <= ctl_d;
        end
      end

      always_comb begin
        slot_word[s] = '0;
        slot_word[s][CTRL_LSB +: CTL_BITS] = ctl_eff;
      end

      assign ctl_o = ctl_eff;
    end else begin : g_plain
      logic [DATA_W-1:0] q, d;
      logic              wr_hit;

      assign wr_hit = wr_en_i && (idx_i == IDX_W'(s));

      always_comb begin
        d = q;
        if (wr_hit) d = wdata_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
      end

      assign slot_word[s] = q;
    end
  end

  assign rd_word_o = slot_word[idx_i];

endmodule

// File: rtl/sysctl_cp_resp.sv
module sysctl_cp_resp
  import sysctl_cp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cp_op_e            op_i,
  input  logic              ctl_wr_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output cp_resp_t          resp_o
);

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  cp_resp_t          resp_q, resp_d;

  assign rdata_en = (op_i == OP_READ);

  always_comb begin
    rdata_d = rdata_q;
    if (rdata_en) rdata_d = rd_word_i;
    resp_d.done     = (op_i == OP_READ) || (op_i == OP_WRITE);
    resp_d.cant     = (op_i == OP_REFUSE);
    resp_d.mode_chg = ctl_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      resp_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      resp_q  <= resp_d;
    end
  end

  assign rdata_o = rdata_q;
  assign resp_o  = resp_q;

endmodule

// File: rtl/sysctl_cp_bank.sv
module sysctl_cp_bank
  import sysctl_cp_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned CTRL_SLOT = 1,
  parameter int unsigned CTRL_LSB  = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h41440110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dir_rd_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [3:0]        strap_mode_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              cant_o,
  output logic              mode_chg_o,
  output logic              prog_wide_o,
  output logic              data_wide_o,
  output logic              late_abort_o,
  output logic              big_endian_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  cp_op_e              op;
  logic [IDX_W-1:0]    idx;
  logic                ctl_wr;
  logic [DATA_W-1:0]   rd_word;
  logic [CTL_BITS-1:0] ctl;
  cp_resp_t            resp;

  sysctl_cp_decode #(
    .NUM_REGS (NUM_REGS),
    .CTRL_SLOT(CTRL_SLOT)
  ) u_decode (
    .req_i   (req_i),
    .dir_rd_i(dir_rd_i),
    .instr_i (instr_i),
    .op_o    (op),
    .idx_o   (idx),
    .ctl_wr_o(ctl_wr)
  );

  sysctl_cp_regs #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .CTRL_SLOT(CTRL_SLOT),
    .CTRL_LSB (CTRL_LSB),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (op == OP_WRITE),
    .idx_i    (idx),
    .wdata_i  (wdata_i),
    .strap_i  (strap_mode_i),
    .rd_word_o(rd_word),
    .ctl_o    (ctl)
  );

  sysctl_cp_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .ctl_wr_i (ctl_wr),
    .rd_word_i(rd_word),
    .rdata_o  (rdata_o),
    .resp_o   (resp)
  );

  assign done_o       = resp.done;
  assign cant_o       = resp.cant;
  assign mode_chg_o   = resp.mode_chg;
  assign prog_wide_o  = ctl[0];
  assign data_wide_o  = ctl[1];
  assign late_abort_o = ctl[2];
  assign big_endian_o = ctl[3];

endmodule

// File: rtl/sysctl_cp_bank_chk.sv
module sysctl_cp_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        dir_rd_i,
  input logic [31:0] instr_i,
  input logic [31:0] rdata_o,
  input logic        done_o,
  input logic        cant_o,
  input logic        mode_chg_o,
  input logic        prog_wide_o,
  input logic        data_wide_o,
  input logic        late_abort_o,
  input logic        big_endian_o
);

  logic [1:0] age_q;
  logic       is_move;
  logic [3:0] ctl_bus;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign is_move = (instr_i[27:24] == 4'b1110) && instr_i[4];
  assign ctl_bus = {big_endian_o, late_abort_o, data_wide_o, prog_wide_o};

  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && cant_o)); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && !cant_o)); // R10
  AST_MOVE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_move) |=> (done_o && !cant_o)); // R3
  AST_REFUSE_CANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_move) |=> (cant_o && !done_o)); // R9
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_move && dir_rd_i && instr_i[18:16] == 3'd0) |=> (rdata_o == 32'h41440110)); // R4
  AST_MODE_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> done_o); // R7
  AST_CTL_ON_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd2) && !$stable(ctl_bus)) |-> mode_chg_o); // R7

endmodule

bind sysctl_cp_bank sysctl_cp_bank_chk u_chk (.*);

// File: tb/sysctl_cp_bank_bench.sv
module sysctl_cp_bank_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] ID_WORD = 32'h41440110;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i;
  logic        dir_rd_i;
  logic [31:0] instr_i;
  logic [31:0] wdata_i;
  logic [3:0]  strap_mode_i;
  logic [31:0] rdata_o;
  logic        done_o, cant_o, mode_chg_o;
  logic        prog_wide_o, data_wide_o, late_abort_o, big_endian_o;

  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysctl_cp_bank u_sysctl_cp_bank (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_move(input logic rd, input int idx);
    return 32'hEE00_0F10 | (32'(idx & 15) << 16) | (rd ? 32'h0010_0000 : 32'h0);
  endfunction

  task automatic xfer(input logic rd, input logic [31:0] ins, input logic [31:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; dir_rd_i = rd; instr_i = ins; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  function automatic logic [3:0] ctl_now();
    return {big_endian_o, late_abort_o, data_wide_o, prog_wide_o};
  endfunction

  task automatic read_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      xfer(1'b1, mk_move(1'b1, s), 32'h0);
      check({tag, " done"}, 32'(done_o), 32'd1);
      check({tag, " read"}, rdata_o, (s == 0) ? ID_WORD : model[s]);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_ni = 1'b0; req_i = 1'b0; dir_rd_i = 1'b0; instr_i = '0; wdata_i = '0;
    strap_mode_i = 4'b1010;
    repeat (3) @(negedge clk_i);
    check("R6 straps in reset", 32'(ctl_now()), 32'hA);
    check("R1 done in reset", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rdata", rdata_o, 32'h0);
    check("R1 flags", {29'h0, done_o, cant_o, mode_chg_o}, 32'h0);
    check("R6 straps held", 32'(ctl_now()), 32'hA);

    model[0] = ID_WORD;
    model[1] = 32'h0000_00A0;
    for (int s = 2; s < 8; s++) model[s] = 32'h0;
    read_all("R8 R6 R4 reset contents");

    for (int i = 0; i < 16; i++) begin
      logic [31:0] pat;
      int s;
      s   = i & 7;
      pat = 32'h9C00_000F ^ (32'(i) << 20) ^ (32'(i * 7) << 4) ^ (32'(i) << 8);
      held = rdata_o;
      xfer(1'b0, mk_move(1'b0, i), pat);
      check("R3 write done", 32'(done_o), 32'd1);
      check("R3 rdata held on write", rdata_o, held);
      check("R7 mode pulse", 32'(mode_chg_o), (s == 1) ? 32'd1 : 32'd0);
      if (s == 1)      model[1] = pat & 32'h0000_00F0;
      else if (s != 0) model[s] = pat;
      check("R5 R7 controls", 32'(ctl_now()), 32'(model[1][7:4]));
      read_all("R2 R4 R5 R8 sweep");
    end

    held = rdata_o;
    xfer(1'b0, 32'hED90_0F00 | (32'd3 << 16), 32'hDEAD_BEEF);
    check("R9 load/store refused", {30'h0, cant_o, done_o}, 32'h2);
    check("R9 rdata kept", rdata_o, held);
    xfer(1'b0, 32'hEE00_0F00 | (32'd1 << 16), 32'h0000_0050);
    check("R9 data op refused", {30'h0, cant_o, done_o}, 32'h2);
    check("R9 no mode pulse", 32'(mode_chg_o), 32'd0);
    check("R9 controls kept", 32'(ctl_now()), 32'(model[1][7:4]));
    xfer(1'b1, 32'hEE00_0F00, 32'h0);
    check("R9 refused read", rdata_o, held);
    read_all("R9 contents kept");

    @(negedge clk_i);
    check("R10 idle", {30'h0, done_o, cant_o}, 32'h0);
    check("R3 done one cycle", 32'(done_o), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule